// File: doc/BRIEF.md
# Register Renamer with Commit-Time Free Pool

This block renames register operands for an out-of-order core. It keeps a speculative table that maps each architectural register to a physical register. It also keeps a committed table holding the last retired mapping of every architectural register, and a bit vector of physical registers that are free.

A dispatch group of up to four lanes is presented each cycle. Every valid lane that writes a register receives a free physical register. Every source operand is translated to the physical register of its youngest earlier writer. If the group asks for more registers than the pool holds, the whole group is held back by the stall output.

When an instruction retires on the commit port, its physical register becomes the committed mapping of its architectural destination. The mapping it displaces goes back to the pool. Because freeing happens only at retirement, no names ever need rewriting anywhere else. A flush input discards all speculative state. It copies the committed table into the speculative table and rebuilds the pool from the registers that the committed table does not reference.

Top module: `rename_unit`

## Requirements
- R1: After reset, architectural register k (0 to 31) maps to physical register k in both tables, and physical registers 32 to 37 are free.
- R2: Each accepted lane with valid and write-enable both high gets the lowest-numbered free physical register. Such lanes are served in ascending lane order, so a higher lane gets a higher number.
- R3: Each valid lane's two sources are translated through the speculative table. A source that matches the destination of a lower, writing lane of the same group instead takes that lane's new register, and the nearest such lane wins.
- R4: Lanes that are invalid, or valid with write-enable low (for example stores), take no register from the pool and leave the speculative table unchanged.
- R5: The stall output is high when the group needs more registers than are free. A stalled group changes no table and takes nothing from the pool.
- R6: On a commit (arch, phys), the committed table entry for arch becomes phys, and the entry it held before is returned to the pool.
- R7: A register returned by a commit in cycle t cannot be allocated in cycle t, and is allocatable from cycle t+1.
- R8: While flush is high, stall is high and dispatch is ignored. In the next cycle the speculative table equals the committed table, including any commit made in the flush cycle, and the pool holds exactly the registers that the committed table does not reference.
- R9: Up to four lanes are renamed per cycle. When two lanes of a group write the same architectural register, the higher lane's register is the one that later groups read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| flush | input | 1 | Restore the speculative state from the committed state |
| disp_valid | input | 4 | Lane valid, one bit per lane |
| disp_wen | input | 4 | Lane writes a destination register |
| disp_dst | input | 20 | Architectural destinations, 5 bits per lane, lane 0 in the low bits |
| disp_src_a | input | 20 | First architectural sources, 5 bits per lane |
| disp_src_b | input | 20 | Second architectural sources, 5 bits per lane |
| stall | output | 1 | Group not accepted this cycle |
| disp_pdst | output | 24 | Allocated physical destinations, 6 bits per lane |
| disp_psrc_a | output | 24 | Translated first sources, 6 bits per lane |
| disp_psrc_b | output | 24 | Translated second sources, 6 bits per lane |
| cmt_valid | input | 1 | A register-writing instruction retires |
| cmt_arch | input | 5 | Architectural destination of the retiring instruction |
| cmt_phys | input | 6 | Physical register of the retiring instruction |

## Verification
Rename results and stall are combinational. They are due in the same cycle as the dispatch group, so the bench drives a group just after a rising edge and compares at the following falling edge. Table writes, commits and flushes take effect at the next rising edge. Their effect is therefore checked through the translated sources and allocated registers of the next group, one cycle after the stimulus. A register freed by a commit is expected to be refused in that same cycle and granted in the next one. The scoreboard model updates its own state only after it has queued the expectation for the current cycle, which keeps this one-cycle offset exact.

// File: rtl/rn_pkg.sv
package rn_pkg;
   localparam int RN_ARCH_DEFAULT  = 32;
   localparam int RN_PHYS_DEFAULT  = 38;
   localparam int RN_LANES_DEFAULT = 4;
endpackage

// File: rtl/rn_free_pool.sv
module rn_free_pool #(
   parameter int NUM_ARCH = 32,
   parameter int NUM_PHYS = 38,
   parameter int LANES    = 4,
   parameter int PW       = $clog2(NUM_PHYS)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [LANES-1:0]         need,
   input  logic                     grant,
   input  logic                     rel_valid,
   input  logic [PW-1:0]            rel_tag,
   input  logic                     rebuild,
   input  logic [NUM_PHYS-1:0]      rebuild_mask,
   output logic [LANES-1:0][PW-1:0] pick_tag,
   output logic                     enough,
   output logic [NUM_PHYS-1:0]      free_vec
);
   logic [NUM_PHYS-1:0] free_q;
   logic [NUM_PHYS-1:0] avail [LANES+1];
   logic [NUM_PHYS-1:0] pick_oh [LANES];
   logic [NUM_PHYS-1:0] alloc_mask;
   logic [NUM_PHYS-1:0] rel_oh;

   function automatic logic [PW-1:0] encode(input logic [NUM_PHYS-1:0] oh);
      logic [PW-1:0] r;
      r = '0;
      for (int p = 0; p < NUM_PHYS; p++)
         if (oh[p]) r = r | PW'(p);
      return r;
   endfunction

   assign avail[0] = free_q;

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      assign pick_oh[l]   = avail[l] & (~avail[l] + NUM_PHYS'(1));
      assign pick_tag[l]  = encode(pick_oh[l]);
      assign avail[l+1]   = need[l] ? (avail[l] & ~pick_oh[l]) : avail[l];
   end

   assign alloc_mask = free_q & ~avail[LANES];
   assign enough     = $countones(need) <= $countones(free_q);
   assign rel_oh     = rel_valid ? (NUM_PHYS'(1) << rel_tag) : '0;
   assign free_vec   = free_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int p = 0; p < NUM_PHYS; p++) free_q[p] <= (p >= NUM_ARCH);
      end else if (rebuild) begin
         free_q <= rebuild_mask;
      end else begin
         free_q <= (free_q & ~(grant ? alloc_mask : '0)) | rel_oh;
      end
   end
endmodule

// File: rtl/rn_commit_map.sv
module rn_commit_map #(
   parameter int NUM_ARCH = 32,
   parameter int NUM_PHYS = 38,
   parameter int AW       = $clog2(NUM_ARCH),
   parameter int PW       = $clog2(NUM_PHYS)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cmt_valid,
   input  logic [AW-1:0]       cmt_arch,
   input  logic [PW-1:0]       cmt_phys,
   output logic [PW-1:0]       old_tag,
   output logic [PW-1:0]       map_next [NUM_ARCH],
   output logic [NUM_PHYS-1:0] unused_mask
);
   logic [PW-1:0] map_q [NUM_ARCH];

   assign old_tag = map_q[cmt_arch];

   always_comb begin
      for (int a = 0; a < NUM_ARCH; a++) map_next[a] = map_q[a];
      if (cmt_valid) map_next[cmt_arch] = cmt_phys;
      unused_mask = '1;
      for (int a = 0; a < NUM_ARCH; a++) unused_mask[map_next[a]] = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int a = 0; a < NUM_ARCH; a++) map_q[a] <= PW'(a);
      end else if (cmt_valid) begin
         map_q[cmt_arch] <= cmt_phys;
      end
   end
endmodule

// File: rtl/rn_spec_map.sv
module rn_spec_map #(
   parameter int NUM_ARCH = 32,
   parameter int NUM_PHYS = 38,
   parameter int LANES    = 4,
   parameter int AW       = $clog2(NUM_ARCH),
   parameter int PW       = $clog2(NUM_PHYS)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [LANES-1:0]         lane_need,
   input  logic [LANES-1:0]         lane_we,
   input  logic [LANES-1:0][AW-1:0] lane_dst,
   input  logic [LANES-1:0][PW-1:0] lane_pdst,
   input  logic [LANES-1:0][AW-1:0] lane_sa,
   input  logic [LANES-1:0][AW-1:0] lane_sb,
   input  logic                     restore,
   input  logic [PW-1:0]            restore_map [NUM_ARCH],
   output logic [LANES-1:0][PW-1:0] lane_psa,
   output logic [LANES-1:0][PW-1:0] lane_psb
);
   logic [PW-1:0] map_q [NUM_ARCH];

   // youngest earlier writer in the group overrides the table
   always_comb begin
      for (int l = 0; l < LANES; l++) begin
         lane_psa[l] = map_q[lane_sa[l]];
         lane_psb[l] = map_q[lane_sb[l]];
         for (int j = 0; j < l; j++) begin
            if (lane_need[j] && lane_dst[j] == lane_sa[l]) lane_psa[l] = lane_pdst[j];
            if (lane_need[j] && lane_dst[j] == lane_sb[l]) lane_psb[l] = lane_pdst[j];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int a = 0; a < NUM_ARCH; a++) map_q[a] <= PW'(a);
      end else if (restore) begin
         for (int a = 0; a < NUM_ARCH; a++) map_q[a] <= restore_map[a];
      end else begin
         for (int l = 0; l < LANES; l++)
            if (lane_we[l]) map_q[lane_dst[l]] <= lane_pdst[l];
      end
   end
endmodule

// File: rtl/rename_unit.sv
module rename_unit #(
   parameter int ARCH_REGS = rn_pkg::RN_ARCH_DEFAULT,
   parameter int PHYS_REGS = rn_pkg::RN_PHYS_DEFAULT,
   parameter int LANES     = rn_pkg::RN_LANES_DEFAULT,
   localparam int AW       = $clog2(ARCH_REGS),
   localparam int PW       = $clog2(PHYS_REGS)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                flush,
   input  logic [LANES-1:0]    disp_valid,
   input  logic [LANES-1:0]    disp_wen,
   input  logic [LANES*AW-1:0] disp_dst,
   input  logic [LANES*AW-1:0] disp_src_a,
   input  logic [LANES*AW-1:0] disp_src_b,
   output logic                stall,
   output logic [LANES*PW-1:0] disp_pdst,
   output logic [LANES*PW-1:0] disp_psrc_a,
   output logic [LANES*PW-1:0] disp_psrc_b,
   input  logic                cmt_valid,
   input  logic [AW-1:0]       cmt_arch,
   input  logic [PW-1:0]       cmt_phys
);
   if (PHYS_REGS <= ARCH_REGS) begin : g_bad_pool
      $error("rename_unit: PHYS_REGS must exceed ARCH_REGS");
   end
   if (LANES < 1) begin : g_bad_lanes
      $error("rename_unit: LANES must be at least 1");
   end
   if (ARCH_REGS != (1 << AW)) begin : g_bad_arch
      $error("rename_unit: ARCH_REGS must be a power of two");
   end

   logic [LANES-1:0]         need;
   logic [LANES-1:0]         lane_we;
   logic                     enough;
   logic                     accept;
   logic [LANES-1:0][PW-1:0] pick_tag;
   logic [LANES-1:0][PW-1:0] psa;
   logic [LANES-1:0][PW-1:0] psb;
   logic [PHYS_REGS-1:0]     free_vec;
   logic [PHYS_REGS-1:0]     unused_mask;
   logic [PW-1:0]            cmt_old;
   logic [PW-1:0]            cmap_next [ARCH_REGS];

   assign need    = disp_valid & disp_wen;
   assign stall   = flush | ~enough;
   assign accept  = ~stall;
   assign lane_we = need & {LANES{accept}};

   assign disp_pdst   = pick_tag;
   assign disp_psrc_a = psa;
   assign disp_psrc_b = psb;

   rn_free_pool #(.NUM_ARCH(ARCH_REGS), .NUM_PHYS(PHYS_REGS), .LANES(LANES), .PW(PW)) u_pool (
      .clk          (clk),
      .rst_n        (rst_n),
      .need         (need),
      .grant        (accept),
      .rel_valid    (cmt_valid),
      .rel_tag      (cmt_old),
      .rebuild      (flush),
      .rebuild_mask (unused_mask),
      .pick_tag     (pick_tag),
      .enough       (enough),
      .free_vec     (free_vec)
   );

   rn_commit_map #(.NUM_ARCH(ARCH_REGS), .NUM_PHYS(PHYS_REGS), .AW(AW), .PW(PW)) u_cmap (
      .clk         (clk),
      .rst_n       (rst_n),
      .cmt_valid   (cmt_valid),
      .cmt_arch    (cmt_arch),
      .cmt_phys    (cmt_phys),
      .old_tag     (cmt_old),
      .map_next    (cmap_next),
      .unused_mask (unused_mask)
   );

   rn_spec_map #(.NUM_ARCH(ARCH_REGS), .NUM_PHYS(PHYS_REGS), .LANES(LANES), .AW(AW), .PW(PW)) u_smap (
      .clk         (clk),
      .rst_n       (rst_n),
      .lane_need   (need),
      .lane_we     (lane_we),
      .lane_dst    (disp_dst),
      .lane_pdst   (pick_tag),
      .lane_sa     (disp_src_a),
      .lane_sb     (disp_src_b),
      .restore     (flush),
      .restore_map (cmap_next),
      .lane_psa    (psa),
      .lane_psb    (psb)
   );
endmodule

// File: rtl/rename_unit_chk.sv
module rename_unit_chk #(
   parameter int ARCH_REGS = 32,
   parameter int PHYS_REGS = 38,
   parameter int LANES     = 4,
   parameter int PW        = 6
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 flush,
   input logic                 stall,
   input logic                 cmt_valid,
   input logic [PW-1:0]        cmt_old,
   input logic [PHYS_REGS-1:0] free_vec,
   input logic [LANES-1:0]     lane_we,
   input logic [LANES*PW-1:0]  disp_pdst
);
   localparam int EXTRA = PHYS_REGS - ARCH_REGS;

   // R6
   no_pool_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(free_vec) <= EXTRA);

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      // R2
      grant_from_pool_chk: assert property (@(posedge clk) disable iff (!rst_n)
         lane_we[l] |-> free_vec[disp_pdst[l*PW +: PW]]);
   end

   // R8
   flush_refill_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> $countones(free_vec) == EXTRA);

   // R5
   stall_holds_pool_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stall && !flush && !cmt_valid) |=> $stable(free_vec));

   // R6
   commit_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmt_valid |=> free_vec[$past(cmt_old)]);
endmodule

bind rename_unit rename_unit_chk #(
   .ARCH_REGS (ARCH_REGS),
   .PHYS_REGS (PHYS_REGS),
   .LANES     (LANES),
   .PW        (PW)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .flush     (flush),
   .stall     (stall),
   .cmt_valid (cmt_valid),
   .cmt_old   (cmt_old),
   .free_vec  (free_vec),
   .lane_we   (lane_we),
   .disp_pdst (disp_pdst)
);

// File: tb/sim_rename_unit.sv
module sim_rename_unit;
   localparam int CLK_PERIOD = 10;

   typedef struct packed {
      logic            stall;
      logic [3:0]      chk;
      logic [3:0]      wchk;
      logic [3:0][5:0] pd;
      logic [3:0][5:0] pa;
      logic [3:0][5:0] pb;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        flush = 1'b0;
   logic [3:0]  disp_valid = '0;
   logic [3:0]  disp_wen = '0;
   logic [19:0] disp_dst = '0;
   logic [19:0] disp_src_a = '0;
   logic [19:0] disp_src_b = '0;
   logic        stall;
   logic [23:0] disp_pdst;
   logic [23:0] disp_psrc_a;
   logic [23:0] disp_psrc_b;
   logic        cmt_valid = 1'b0;
   logic [4:0]  cmt_arch = '0;
   logic [5:0]  cmt_phys = '0;

   rename_unit u0 (.*);

   always #(CLK_PERIOD/2) clk = ~clk;

   int total = 0;
   int fails = 0;
   bit done = 0;

   exp_t  q[$];
   string tq[$];

   // bench model
   int smap [32];
   int cmap [32];
   bit freem [38];
   int ifa[$];
   int ifp[$];

   // stimulus of the current step
   logic [3:0] v_valid, v_wen;
   int v_dst [4], v_sa [4], v_sb [4];
   bit v_cmt, v_fl;

   task automatic check(string tag, string what, int act, int exp);
      total++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   task automatic clr();
      v_valid = '0; v_wen = '0; v_cmt = 0; v_fl = 0;
      for (int l = 0; l < 4; l++) begin v_dst[l] = 0; v_sa[l] = 0; v_sb[l] = 0; end
   endtask

   task automatic lane(int l, bit w, int d, int a, int b);
      v_valid[l] = 1'b1; v_wen[l] = w; v_dst[l] = d; v_sa[l] = a; v_sb[l] = b;
   endtask

   task automatic step(string tag);
      exp_t e;
      int need, fcnt, old, ca, cp;
      bit tf [38];
      bit cm;
      @(posedge clk); #1;
      cm = v_cmt && (ifa.size() > 0);
      flush = v_fl; disp_valid = v_valid; disp_wen = v_wen;
      for (int l = 0; l < 4; l++) begin
         disp_dst[l*5 +: 5] = 5'(v_dst[l]);
         disp_src_a[l*5 +: 5] = 5'(v_sa[l]);
         disp_src_b[l*5 +: 5] = 5'(v_sb[l]);
      end
      cmt_valid = cm;
      cmt_arch = cm ? 5'(ifa[0]) : '0;
      cmt_phys = cm ? 6'(ifp[0]) : '0;
      need = 0; fcnt = 0;
      for (int l = 0; l < 4; l++) if (v_valid[l] && v_wen[l]) need++;
      for (int p = 0; p < 38; p++) begin tf[p] = freem[p]; if (freem[p]) fcnt++; end
      e = '0;
      e.stall = v_fl || (need > fcnt);
      if (!e.stall) begin
         e.chk = v_valid; e.wchk = v_valid & v_wen;
         for (int l = 0; l < 4; l++) begin
            if (!v_valid[l]) continue;
            e.pa[l] = 6'(smap[v_sa[l]]); e.pb[l] = 6'(smap[v_sb[l]]);
            for (int j = 0; j < l; j++) if (e.wchk[j]) begin
               if (v_dst[j] == v_sa[l]) e.pa[l] = e.pd[j];
               if (v_dst[j] == v_sb[l]) e.pb[l] = e.pd[j];
            end
            if (v_wen[l]) begin
               for (int p = 37; p >= 0; p--) if (tf[p]) e.pd[l] = 6'(p);
               tf[e.pd[l]] = 0;
            end
         end
      end
      q.push_back(e); tq.push_back(tag);
      // advance the model to the state after this edge
      old = -1;
      if (cm) begin
         ca = ifa.pop_front(); cp = ifp.pop_front();
         old = cmap[ca]; cmap[ca] = cp;
      end
      if (v_fl) begin
         for (int p = 0; p < 38; p++) freem[p] = 1;
         for (int a = 0; a < 32; a++) begin smap[a] = cmap[a]; freem[cmap[a]] = 0; end
         ifa.delete(); ifp.delete();
      end else begin
         if (!e.stall)
            for (int l = 0; l < 4; l++) if (e.wchk[l]) begin
               freem[e.pd[l]] = 0; smap[v_dst[l]] = e.pd[l];
               ifa.push_back(v_dst[l]); ifp.push_back(e.pd[l]);
            end
         if (old >= 0) freem[old] = 1;
      end
   endtask

   // monitor: compares at the falling edge of the cycle the group was driven
   exp_t  m_e;
   string m_t;
   always @(negedge clk) begin
      if (rst_n && q.size() > 0) begin
         m_e = q.pop_front(); m_t = tq.pop_front();
         check(m_t, "stall", int'(stall), int'(m_e.stall));
         for (int l = 0; l < 4; l++) begin
            if (m_e.chk[l]) begin
               check(m_t, $sformatf("lane%0d psrc_a", l), int'(disp_psrc_a[l*6 +: 6]), int'(m_e.pa[l]));
               check(m_t, $sformatf("lane%0d psrc_b", l), int'(disp_psrc_b[l*6 +: 6]), int'(m_e.pb[l]));
            end
            if (m_e.wchk[l])
               check(m_t, $sformatf("lane%0d pdst", l), int'(disp_pdst[l*6 +: 6]), int'(m_e.pd[l]));
         end
      end
   end

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         fails++; total++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("%0d/%0d checks passed", total - fails, total);
         $finish;
      end
   end

   initial begin
      for (int a = 0; a < 32; a++) begin smap[a] = a; cmap[a] = a; end
      for (int p = 0; p < 38; p++) freem[p] = (p >= 32);
      clr();
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1 identity map after reset, no writers
      clr(); lane(0,0,0,0,28); lane(1,0,0,1,29); lane(2,0,0,2,30); lane(3,0,0,31,3);
      step("R1");
      // R2 first allocations come from 32 upward; R3 lane1 bypasses lane0
      clr(); lane(0,1,1,1,5); lane(1,1,2,1,6); lane(2,1,3,2,1); lane(3,1,4,9,3);
      step("R2 R3");
      // R4 store lanes take nothing: two writers get 36 and 37
      clr(); lane(0,0,7,1,2); lane(1,1,5,3,4); lane(2,0,9,5,1); lane(3,1,6,5,6);
      step("R4");
      // R5 pool empty: stall; R7 commit this cycle does not help yet
      clr(); lane(0,1,8,1,2); v_cmt = 1;
      step("R5 R7");
      // R7 register freed last cycle (P1) is granted now; R6
      clr(); lane(0,1,8,1,8);
      step("R7 R6");
      // R6 further commits return displaced registers
      clr(); v_cmt = 1; lane(0,0,0,8,5); step("R6");
      clr(); v_cmt = 1; step("R6");
      clr(); v_cmt = 1; step("R6");
      // R9 two lanes write register 10; later group reads the higher lane's tag
      clr(); lane(0,1,10,10,1); lane(1,1,10,10,2); step("R9");
      clr(); lane(0,0,0,10,10); step("R9");
      // R8 flush with a commit in the same cycle, then read back
      clr(); v_cmt = 1; v_fl = 1; lane(0,1,3,3,3); step("R8");
      clr(); lane(0,1,11,1,2); lane(1,1,12,3,4); lane(2,1,13,10,8);
      lane(3,1,14,5,6); step("R8");
      clr(); lane(0,1,15,11,12); lane(1,1,16,13,14); step("R8");

      // mixed traffic
      for (int n = 0; n < 600; n++) begin
         clr();
         for (int l = 0; l < 4; l++)
            if ($urandom % 3 != 0)
               lane(l, ($urandom % 4) != 0, $urandom % 32, $urandom % 32, $urandom % 32);
         v_cmt = ($urandom % 4) != 0;
         v_fl  = ($urandom % 50) == 0;
         step("R3 R5 R9 mixed");
      end

      clr(); step("R1 idle");
      @(posedge clk); #1;
      disp_valid = '0; cmt_valid = 1'b0; flush = 1'b0;
      @(negedge clk); #1;
      done = 1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end
endmodule